// File: doc/BRIEF.md
# Temperature Threshold Alarm Register Bank

This block is the register side of an on-board temperature monitor. Temperature readings arrive on a small valid/ready sample stream as 11-bit two's-complement codes in quarter-degree steps, covering -256.00 to +255.75 degrees. The bank keeps the most recent reading and four programmable limits: high, low, critical and low-critical. Each accepted reading is compared with the four limits using signed arithmetic. A reading that crosses a limit sets a sticky alarm bit, and software clears these bits by writing a mask to a write-one-to-clear register.

Software reaches the bank through a plain synchronous byte port that carries an address, write data, a write strobe, a read strobe and registered read data. Every 16-bit value sits in two bytes, with the low byte at the lower address and the code in bits [12:2]. Identification bytes give the capability, the revision and a parity-protected vendor code. One configuration bit stops the sensor path. The sample stream never applies back-pressure: `sample_ready` is always high, so each cycle with `sample_valid` high transfers one reading. A reading that arrives while the sensor is disabled is accepted and then discarded.

Top module: `tmon_regbank`

## Requirements
- R1: After reset, the four limits, the latest reading, the alarm bits and the disable bit are all zero, and reading any of them returns 0x00.
- R2: Limit i (0 high, 1 low, 2 critical, 3 low-critical) has its low byte at 0x1C+2i and its high byte at 0x1D+2i. A write keeps only bits [7:2] of the low byte and bits [4:0] of the high byte. Every other bit reads back as zero.
- R3: An accepted reading with the sensor enabled is stored as code<<2 and read back as low byte 0x31 and high byte 0x32. `sample_ready` is always 1.
- R4: On an accepted, enabled reading, status bit 0 sets if the reading is greater than the high limit, and status bit 2 sets if it is greater than the critical limit. Both compares are signed, and a reading equal to a limit raises nothing.
- R5: On an accepted, enabled reading, status bit 1 sets if the reading is less than the low limit, and status bit 3 sets if it is less than the low-critical limit. Both compares are signed.
- R6: Status bits at 0x33 stay set until software writes a 1 to the matching bit of 0x13. If an alarm is raised in the same cycle as its clear, the alarm wins. Reads of 0x13 and 0x14 return 0x00.
- R7: Bit 0 of 0x1A disables the sensor and bits [7:1] read as zero. While the bit is set, readings leave the stored temperature and the alarm bits unchanged.
- R8: Address 0x05 reads 0x02. Address 0x02 reads (major-1) in bits [5:4] and (minor-1) in bits [3:1], which is 0x14 with the defaults. Addresses 0x03 and 0x04 hold 7-bit codes with odd parity in bit 7, which is 0x83 and 0x32 with the defaults.
- R9: Writes to any address other than 0x13, 0x1A or the eight limit bytes have no effect. This covers the reading, the status and the identification bytes. Unmapped addresses read 0x00.
- R10: Read data appears on `reg_rd_data` on the clock edge that samples `reg_rd_en`, shows the state before any write in that same cycle, and holds while `reg_rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | Reading present on sample_code |
| sample_ready | output | 1 | Always 1; the bank never stalls the stream |
| sample_code | input | 11 | Signed quarter-degree reading |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 8 | Write data |
| reg_wr_en | input | 1 | Write strobe |
| reg_rd_en | input | 1 | Read strobe |
| reg_rd_data | output | 8 | Registered read data |

## Verification
The hardest case to reach from the ports is a single cycle that carries both a new alarm and a clear for that same bit, together with limit writes that change the compare operands at the edge where they are used. The stimulus drives random mixes of sample, write and read in the same cycle against a bench model that applies limit changes only after the compare. Directed steps add readings equal to a limit and readings at the extreme codes -1024 and +1023, so every compare is tested at its boundary.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
  localparam int NUM_LIM = 4;
  localparam logic [7:0] A_REV     = 8'h02;
  localparam logic [7:0] A_VEN0    = 8'h03;
  localparam logic [7:0] A_VEN1    = 8'h04;
  localparam logic [7:0] A_CAP     = 8'h05;
  localparam logic [7:0] A_CLR     = 8'h13;
  localparam logic [7:0] A_ERRCLR  = 8'h14;
  localparam logic [7:0] A_CFG     = 8'h1A;
  localparam logic [7:0] A_LIMBASE = 8'h1C;
  localparam logic [7:0] A_TMP_LO  = 8'h31;
  localparam logic [7:0] A_TMP_HI  = 8'h32;
  localparam logic [7:0] A_STAT    = 8'h33;

  function automatic logic [7:0] odd_par_byte(input logic [6:0] code);
    return {~^code, code};
  endfunction
endpackage

// File: rtl/tmon_limit_bank.sv
module tmon_limit_bank #(
  parameter int TEMP_W = 11,
  parameter int NUM    = 4,
  parameter int ADDR_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [7:0]                  wdata,
  output logic [NUM-1:0][TEMP_W-1:0]  lim
);
  localparam int LO_W = 6;
  localparam int HI_W = TEMP_W - LO_W;

  for (genvar g = 0; g < NUM; g++) begin : g_lim
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(int'(tmon_pkg::A_LIMBASE) + 2*g);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(int'(tmon_pkg::A_LIMBASE) + 2*g + 1);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lim[g] <= '0;
      end else if (wr_en) begin
        if (addr == LO_A) lim[g][LO_W-1:0]      <= wdata[7:2];
        if (addr == HI_A) lim[g][TEMP_W-1:LO_W] <= wdata[HI_W-1:0];
      end
    end
  end
endmodule

// File: rtl/tmon_alarm_eval.sv
module tmon_alarm_eval #(
  parameter int TEMP_W = 11,
  parameter int NUM    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fire,
  input  logic [TEMP_W-1:0]           code,
  input  logic [NUM-1:0][TEMP_W-1:0]  lim,
  input  logic [NUM-1:0]              clr_mask,
  output logic [NUM-1:0]              status
);
  logic [NUM-1:0] hit;

  // even index: upper limit (greater-than); odd index: lower limit (less-than)
  for (genvar g = 0; g < NUM; g++) begin : g_cmp
    if (g % 2 == 0) begin : g_up
      assign hit[g] = $signed(code) > $signed(lim[g]);
    end else begin : g_dn
      assign hit[g] = $signed(code) < $signed(lim[g]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_mask) | (fire ? hit : '0);
  end
endmodule

// File: rtl/tmon_read_mux.sv
module tmon_read_mux #(
  parameter int TEMP_W = 11,
  parameter int NUM    = 4,
  parameter int ADDR_W = 8,
  parameter int REV_MAJOR = 2,
  parameter int REV_MINOR = 3,
  parameter logic [6:0] VEN_BANK = 7'h03,
  parameter logic [6:0] VEN_CODE = 7'h32
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic [NUM-1:0][TEMP_W-1:0]  lim,
  input  logic [TEMP_W-1:0]           temp,
  input  logic [NUM-1:0]              status,
  input  logic                        dis,
  output logic [7:0]                  rdata
);
  import tmon_pkg::*;
  localparam int LO_W = 6;
  localparam int HI_W = TEMP_W - LO_W;
  localparam logic [7:0] REV_BYTE = {2'b00, 2'(REV_MAJOR - 1), 3'(REV_MINOR - 1), 1'b0};

  function automatic logic [7:0] lo_byte(input logic [TEMP_W-1:0] v);
    return {v[LO_W-1:0], 2'b00};
  endfunction
  function automatic logic [7:0] hi_byte(input logic [TEMP_W-1:0] v);
    return 8'(v[TEMP_W-1:LO_W]);
  endfunction

  always_comb begin
    rdata = 8'h00;
    case (8'(addr))
      A_REV:    rdata = REV_BYTE;
      A_VEN0:   rdata = odd_par_byte(VEN_BANK);
      A_VEN1:   rdata = odd_par_byte(VEN_CODE);
      A_CAP:    rdata = 8'h02;
      A_CFG:    rdata = {7'd0, dis};
      A_TMP_LO: rdata = lo_byte(temp);
      A_TMP_HI: rdata = hi_byte(temp);
      A_STAT:   rdata = 8'(status);
      default: begin
        for (int i = 0; i < NUM; i++) begin
          if (8'(addr) == 8'(int'(A_LIMBASE) + 2*i))     rdata = lo_byte(lim[i]);
          if (8'(addr) == 8'(int'(A_LIMBASE) + 2*i + 1)) rdata = hi_byte(lim[i]);
        end
      end
    endcase
  end
endmodule

// File: rtl/tmon_regbank.sv
module tmon_regbank #(
  parameter int TEMP_W = 11,
  parameter int ADDR_W = 8,
  parameter int REV_MAJOR = 2,
  parameter int REV_MINOR = 3,
  parameter logic [6:0] VEN_BANK = 7'h03,
  parameter logic [6:0] VEN_CODE = 7'h32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_valid,
  output logic              sample_ready,
  input  logic [TEMP_W-1:0] sample_code,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  output logic [7:0]        reg_rd_data
);
  import tmon_pkg::*;
  localparam int NUM = NUM_LIM;

  logic [NUM-1:0][TEMP_W-1:0] lim;
  logic [TEMP_W-1:0]          temp_q;
  logic [NUM-1:0]             status_q;
  logic [NUM-1:0]             clr_mask;
  logic                       dis_q;
  logic                       fire;
  logic [7:0]                 rd_mux;

  assign sample_ready = 1'b1;
  assign fire     = sample_valid && !dis_q;
  assign clr_mask = (reg_wr_en && 8'(reg_addr) == A_CLR) ? reg_wdata[NUM-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      temp_q <= '0;
      dis_q  <= 1'b0;
    end else begin
      if (fire) temp_q <= sample_code;
      if (reg_wr_en && 8'(reg_addr) == A_CFG) dis_q <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         reg_rd_data <= 8'h00;
    else if (reg_rd_en) reg_rd_data <= rd_mux;
  end

  tmon_limit_bank #(.TEMP_W(TEMP_W), .NUM(NUM), .ADDR_W(ADDR_W)) u_lim (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .lim(lim));

  tmon_alarm_eval #(.TEMP_W(TEMP_W), .NUM(NUM)) u_alarm (
    .clk(clk), .rst_n(rst_n), .fire(fire), .code(sample_code), .lim(lim),
    .clr_mask(clr_mask), .status(status_q));

  tmon_read_mux #(.TEMP_W(TEMP_W), .NUM(NUM), .ADDR_W(ADDR_W),
    .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR),
    .VEN_BANK(VEN_BANK), .VEN_CODE(VEN_CODE)) u_rmux (
    .addr(reg_addr), .lim(lim), .temp(temp_q), .status(status_q),
    .dis(dis_q), .rdata(rd_mux));
endmodule

// File: rtl/tmon_regbank_chk.sv
module tmon_regbank_chk #(
  parameter int TEMP_W = 11,
  parameter int ADDR_W = 8,
  parameter int NUM    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_valid,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              reg_wr_en,
  input logic              reg_rd_en,
  input logic [7:0]        reg_rd_data,
  input logic [NUM-1:0]    stat,
  input logic [TEMP_W-1:0] temp_q,
  input logic              dis_q
);
  import tmon_pkg::*;
  logic [NUM-1:0] wr_clr;
  assign wr_clr = (reg_wr_en && 8'(reg_addr) == A_CLR) ? reg_wdata[NUM-1:0] : '0;

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat) & ~$past(wr_clr) & ~stat) == '0));

  // R5 shares this check: no alarm bit rises without an enabled reading
  assert_no_spurious_alarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_valid && !dis_q) |=> ((stat & ~$past(stat)) == '0));

  assert_disabled_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_q && sample_valid) |=> $stable(temp_q));

  assert_clr_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && (8'(reg_addr) == A_CLR || 8'(reg_addr) == A_ERRCLR)) |=> (reg_rd_data == 8'h00));

  assert_cfg_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && 8'(reg_addr) == A_CFG) |=> (reg_rd_data[7:1] == 7'd0));

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> $stable(reg_rd_data));
endmodule

bind tmon_regbank tmon_regbank_chk #(.TEMP_W(TEMP_W), .ADDR_W(ADDR_W), .NUM(tmon_pkg::NUM_LIM)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
  .reg_rd_data(reg_rd_data), .stat(status_q), .temp_q(temp_q), .dis_q(dis_q));

// File: tb/sim_tmon_regbank.sv
`timescale 1ns/1ps
module sim_tmon_regbank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_valid = 1'b0;
  logic sample_ready;
  logic [10:0] sample_code = '0;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic reg_wr_en = 1'b0;
  logic reg_rd_en = 1'b0;
  logic [7:0] reg_rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [10:0] m_lim [4];
  logic [10:0] m_temp;
  logic [3:0]  m_stat;
  logic        m_dis;

  always #4 clk = ~clk;

  tmon_regbank u0 (.clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
    .sample_ready(sample_ready), .sample_code(sample_code), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_rd_data(reg_rd_data));

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    logic [7:0] r = 8'h00;
    case (a)
      8'h02: r = 8'h14;
      8'h03: r = 8'h83;
      8'h04: r = 8'h32;
      8'h05: r = 8'h02;
      8'h1A: r = {7'd0, m_dis};
      8'h31: r = {m_temp[5:0], 2'b00};
      8'h32: r = {3'b000, m_temp[10:6]};
      8'h33: r = {4'h0, m_stat};
      default: begin
        for (int i = 0; i < 4; i++) begin
          if (a == 8'(8'h1C + 2*i))     r = {m_lim[i][5:0], 2'b00};
          if (a == 8'(8'h1C + 2*i + 1)) r = {3'b000, m_lim[i][10:6]};
        end
      end
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a >= 8'h1C && a <= 8'h23) return "R2";
    if (a == 8'h31 || a == 8'h32) return "R3";
    if (a == 8'h33) return "R4";
    if (a == 8'h13 || a == 8'h14) return "R6";
    if (a == 8'h1A) return "R7";
    if (a >= 8'h02 && a <= 8'h05) return "R8";
    return "R9";
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) m_lim[i] = '0;
    m_temp = '0; m_stat = '0; m_dis = 1'b0;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic step(input bit we, input bit re, input logic [7:0] a, input logic [7:0] d,
                      input bit sv, input logic [10:0] sc, input string tag);
    logic [7:0] ex;
    logic [3:0] hits;
    @(negedge clk);
    reg_wr_en = we; reg_rd_en = re; reg_addr = a; reg_wdata = d;
    sample_valid = sv; sample_code = sc;
    ex = exp_read(a);
    hits = '0;
    if (sv && !m_dis) begin
      hits[0] = $signed(sc) > $signed(m_lim[0]);
      hits[1] = $signed(sc) < $signed(m_lim[1]);
      hits[2] = $signed(sc) > $signed(m_lim[2]);
      hits[3] = $signed(sc) < $signed(m_lim[3]);
    end
    @(posedge clk);
    if (sv && !m_dis) m_temp = sc;
    if (we && a == 8'h13) m_stat = m_stat & ~d[3:0];
    m_stat = m_stat | hits;
    if (we) begin
      if (a == 8'h1A) m_dis = d[0];
      for (int i = 0; i < 4; i++) begin
        if (a == 8'(8'h1C + 2*i))     m_lim[i][5:0]  = d[7:2];
        if (a == 8'(8'h1C + 2*i + 1)) m_lim[i][10:6] = d[4:0];
      end
    end
    @(negedge clk);
    if (re) check(tag, reg_rd_data, ex);
    reg_wr_en = 1'b0; reg_rd_en = 1'b0; sample_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    step(1'b0, 1'b1, a, 8'h00, 1'b0, 11'd0, tag);
  endtask
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    step(1'b1, 1'b0, a, d, 1'b0, 11'd0, "");
  endtask
  task automatic smp(input logic [10:0] c);
    step(1'b0, 1'b0, 8'h00, 8'h00, 1'b1, c, "");
  endtask
  task automatic set_lim(input int i, input logic [10:0] c);
    wr(8'(8'h1C + 2*i), {c[5:0], 2'b00});
    wr(8'(8'h1C + 2*i + 1), {3'b000, c[10:6]});
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, R8 identification bytes
    for (int a = 8'h1C; a <= 8'h23; a++) rd(8'(a), "R1");
    rd(8'h31, "R1"); rd(8'h32, "R1"); rd(8'h33, "R1"); rd(8'h1A, "R1");
    rd(8'h02, "R8"); rd(8'h03, "R8"); rd(8'h04, "R8"); rd(8'h05, "R8");
    checks++; if (sample_ready !== 1'b1) begin failures++; $display("FAIL R3 actual=%b expected=1", sample_ready); end
    // R2 trimmed bits
    wr(8'h1C, 8'hFF); wr(8'h1D, 8'hFF);
    rd(8'h1C, "R2"); rd(8'h1D, "R2");
    // R4 equal to limit raises nothing, one above does
    set_lim(0, 11'd40); set_lim(2, 11'd400); set_lim(1, 11'h400); set_lim(3, 11'h400);
    smp(11'd40); rd(8'h33, "R4");
    smp(11'd41); rd(8'h33, "R4");
    smp(11'd1023); rd(8'h33, "R4"); rd(8'h31, "R3"); rd(8'h32, "R3");
    // R5 extreme negative equal to lower limits
    smp(11'h400); rd(8'h33, "R5");
    set_lim(1, 11'h7FF);
    smp(11'h400); rd(8'h33, "R5");
    // R6 clear, sticky, simultaneous set wins, readback zero
    wr(8'h13, 8'h01); rd(8'h33, "R6");
    step(1'b1, 1'b0, 8'h13, 8'h0F, 1'b1, 11'd50, "");
    rd(8'h33, "R6"); rd(8'h13, "R6"); rd(8'h14, "R6");
    wr(8'h13, 8'h0F); rd(8'h33, "R6");
    // R7 disable ignores samples
    wr(8'h1A, 8'hFF); rd(8'h1A, "R7");
    smp(11'd1000); rd(8'h33, "R7"); rd(8'h31, "R7");
    wr(8'h1A, 8'h00);
    // R9 read-only writes ignored
    wr(8'h33, 8'h0F); wr(8'h31, 8'hAA); wr(8'h05, 8'hFF); wr(8'h40, 8'h55);
    rd(8'h33, "R9"); rd(8'h31, "R9"); rd(8'h05, "R9"); rd(8'h40, "R9");
    // R10 read shows pre-write state in the same cycle
    step(1'b1, 1'b1, 8'h20, 8'hA8, 1'b0, 11'd0, "R10");
    rd(8'h20, "R10");
    // random mix
    for (int n = 0; n < 1500; n++) begin
      int k = int'($urandom_range(0, 9));
      logic [7:0] a;
      logic [7:0] d = 8'($urandom);
      if (k < 3)      a = 8'(8'h1C + $urandom_range(0, 7));
      else if (k < 4) a = 8'h13;
      else if (k < 5) a = (($urandom_range(0, 7) == 0) ? 8'h1A : 8'h33);
      else            a = 8'($urandom_range(0, 8'h3F));
      if (a == 8'h1A) d[0] = ($urandom_range(0, 3) == 0);
      step($urandom_range(0, 1) == 1, 1'b1, a, d, $urandom_range(0, 1) == 1,
           11'($urandom), tag_of(a));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule